// File: doc/BRIEF.md
# Smart Card Activation Sequencer

This controller brings a contact smart card up and down in a fixed, timed order and watches for faults while a session runs. A host starts a session by pulling an active-low request low. The block then switches its internal oscillator to the fast rate, turns on the card supply, enables the data lines, starts the card clock and finally hands the card reset line to the host. When the host releases the request, or when a fault appears, the block runs the steps in reverse order and waits for the card supply to report that it is off.

All timing is counted in oscillator ticks, which arrive as a one-cycle enable. One unit T is `TICKS_PER_T` ticks, and the steps fall on half-T boundaries. A presence debouncer qualifies card insertion, and an active-low status line tells the host whether a card is present or whether a session ended on a fault. After a fault the block will not start again until the host has released the request and asserted it once more.

Top module: `scs_activation_seq`

## Requirements
- R1: After reset every card-side output (supply, data enable, clock gate, card reset) is low, the oscillator fast flag is low and, with no card detected, status_n is low.
- R2: status_n rises only after card_det has been high for `DEBOUNCE_TICKS` consecutive oscillator ticks. A low card_det drops the debounced presence, and with it status_n, on the next clock.
- R3: A session starts only from idle, with the request low, the block armed by an earlier high request, the debounced presence true and supply_ok high. osc_fast is high from session start until power-down completes.
- R4: Counting in half-T units (half of `TICKS_PER_T` ticks) from session start, vcc_en rises at start, io_en rises at 8 half-T units (4T), and the sequence ends at 14 half-T units (7T).
- R5: card_rst stays low until the end of the power-up sequence. After that it equals host_rst in the same cycle.
- R6: If host_rst is low at session start, clk_en rises at 4T. If host_rst is high at session start, clk_en rises on the clock after host_rst is first seen falling at or after 4T. At 7T the clock is on, whatever host_rst does.
- R7: On power-down, card_rst drops at once, clk_en drops at 0.5T, io_en at 1T and vcc_en at 1.5T. Only outputs that were on are on during this phase. The block returns to idle on the first clock with at least 1.5T elapsed and vcc_off high.
- R8: During power-up or an active session, any of over_cur, over_temp, low supply_ok or low card_det (not debounced) starts power-down on the next clock and drives status_n low.
- R9: over_cur and over_temp have no effect while no session is running.
- R10: After a fault-driven power-down, a request held low does not start a new session. The request must go high and then low again.
- R11: The fault indication on status_n clears once the block is idle and the request is high. status_n then shows the debounced presence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle enable per internal oscillator tick |
| sess_req_n | input | 1 | Active-low session request from host |
| host_rst | input | 1 | Host reset level for the card |
| card_det | input | 1 | Raw card presence, high when inserted |
| supply_ok | input | 1 | Main supply above threshold |
| over_cur | input | 1 | Card supply overcurrent flag |
| over_temp | input | 1 | Overtemperature flag |
| vcc_off | input | 1 | Card supply has fallen to its off level |
| osc_fast | output | 1 | Request for fast oscillator rate |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card data-line enable |
| clk_en | output | 1 | Card clock gate |
| card_rst | output | 1 | Card reset line |
| status_n | output | 1 | Active-low status/interrupt: low means no card or fault |

## Verification
The assertions assume that all inputs are synchronous to clk and change only between edges. They also assume that a card reset can only be high while supply, data and clock are all on, so the trip checks can use card_rst as a marker that a session is live. The stimulus drives every input shortly after a rising edge and holds it for whole cycles. It raises faults only while a session is idle or running, and it keeps vcc_off high except during one long wait. This keeps the input sequences within those assumptions.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAMP = 2'd1,
    ST_LIVE = 2'd2,
    ST_DOWN = 2'd3
  } scs_state_e;

  // step positions in half-T units
  localparam int HALF_W       = 5;
  localparam int STEP_IO_ON   = 8;
  localparam int STEP_DONE    = 14;
  localparam int STEP_CLK_OFF = 1;
  localparam int STEP_IO_OFF  = 2;
  localparam int STEP_VCC_OFF = 3;
endpackage

// File: rtl/scs_presence.sv
module scs_presence #(
  parameter int DEBOUNCE_TICKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic present
);
  localparam int CW = $clog2(DEBOUNCE_TICKS + 1);
  logic [CW-1:0] cnt;

  // insertion must hold for the full window; removal clears at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present <= 1'b0;
      cnt     <= '0;
    end else if (!raw) begin
      present <= 1'b0;
      cnt     <= '0;
    end else if (!present && tick) begin
      if (cnt == CW'(DEBOUNCE_TICKS - 1)) present <= 1'b1;
      else                                cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scs_timebase.sv
module scs_timebase import scs_pkg::*; #(
  parameter int HALF_TICKS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clr,
  output logic [HALF_W-1:0] half
);
  localparam int TW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      half <= '0;
    end else if (clr) begin
      tcnt <= '0;
      half <= '0;
    end else if (tick) begin
      if (tcnt == TW'(HALF_TICKS - 1)) begin
        tcnt <= '0;
        if (half != '1) half <= half + 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scs_fsm.sv
module scs_fsm import scs_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sess_req_n,
  input  logic              host_rst,
  input  logic              card_det,
  input  logic              present,
  input  logic              supply_ok,
  input  logic              over_cur,
  input  logic              over_temp,
  input  logic              vcc_off,
  input  logic [HALF_W-1:0] half,
  output scs_state_e        state,
  output logic              tb_clr,
  output logic              rst_at_start,
  output logic              clk_go,
  output logic              fault_lat
);
  scs_state_e nxt;
  logic fault, start, armed, hr_prev;

  always_comb begin
    fault = ((state == ST_RAMP) || (state == ST_LIVE)) &&
            (over_cur || over_temp || !supply_ok || !card_det);
    start = armed && !sess_req_n && present && supply_ok;
    nxt   = state;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_RAMP;
      ST_RAMP: begin
        if (fault || sess_req_n)                  nxt = ST_DOWN;
        else if (half >= HALF_W'(STEP_DONE))      nxt = ST_LIVE;
      end
      ST_LIVE: if (fault || sess_req_n)           nxt = ST_DOWN;
      ST_DOWN: if (half >= HALF_W'(STEP_VCC_OFF) && vcc_off) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    tb_clr = (nxt != state);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      hr_prev      <= 1'b0;
      rst_at_start <= 1'b0;
      clk_go       <= 1'b0;
      armed        <= 1'b0;
      fault_lat    <= 1'b0;
    end else begin
      state   <= nxt;
      hr_prev <= host_rst;
      if (state == ST_IDLE && start) begin
        rst_at_start <= host_rst;
        clk_go       <= 1'b0;
      end else if (state == ST_RAMP && rst_at_start && hr_prev && !host_rst &&
                   half >= HALF_W'(STEP_IO_ON)) begin
        clk_go <= 1'b1;
      end
      if (state == ST_IDLE) begin
        if (start)           armed <= 1'b0;
        else if (sess_req_n) armed <= 1'b1;
      end
      if (fault)                                 fault_lat <= 1'b1;
      else if (state == ST_IDLE && sess_req_n)   fault_lat <= 1'b0;
    end
  end
endmodule

// File: rtl/scs_activation_seq.sv
module scs_activation_seq import scs_pkg::*; #(
  parameter int TICKS_PER_T    = 64,
  parameter int DEBOUNCE_TICKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic sess_req_n,
  input  logic host_rst,
  input  logic card_det,
  input  logic supply_ok,
  input  logic over_cur,
  input  logic over_temp,
  input  logic vcc_off,
  output logic osc_fast,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic status_n
);
  localparam int HALF_TICKS = TICKS_PER_T / 2;

  scs_state_e        state;
  logic [HALF_W-1:0] half;
  logic present, tb_clr, rst_at_start, clk_go, fault_lat;
  logic vcc_q, io_q, clk_q;

  scs_presence #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_pres (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .raw(card_det), .present(present)
  );

  scs_timebase #(.HALF_TICKS(HALF_TICKS)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .clr(tb_clr), .half(half)
  );

  scs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sess_req_n(sess_req_n), .host_rst(host_rst),
    .card_det(card_det), .present(present), .supply_ok(supply_ok),
    .over_cur(over_cur), .over_temp(over_temp), .vcc_off(vcc_off), .half(half),
    .state(state), .tb_clr(tb_clr), .rst_at_start(rst_at_start),
    .clk_go(clk_go), .fault_lat(fault_lat)
  );

  always_comb begin
    osc_fast = (state != ST_IDLE);
    vcc_en   = 1'b0;
    io_en    = 1'b0;
    clk_en   = 1'b0;
    unique case (state)
      ST_RAMP: begin
        vcc_en = 1'b1;
        io_en  = (half >= HALF_W'(STEP_IO_ON));
        clk_en = rst_at_start ? clk_go : (half >= HALF_W'(STEP_IO_ON));
      end
      ST_LIVE: begin
        vcc_en = 1'b1;
        io_en  = 1'b1;
        clk_en = 1'b1;
      end
      ST_DOWN: begin
        // only outputs that were on stay on until their off step
        vcc_en = vcc_q && (half < HALF_W'(STEP_VCC_OFF));
        io_en  = io_q  && (half < HALF_W'(STEP_IO_OFF));
        clk_en = clk_q && (half < HALF_W'(STEP_CLK_OFF));
      end
      default: ;
    endcase
    card_rst = (state == ST_LIVE) && host_rst;
    status_n = present && !fault_lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcc_q <= 1'b0;
      io_q  <= 1'b0;
      clk_q <= 1'b0;
    end else begin
      vcc_q <= vcc_en;
      io_q  <= io_en;
      clk_q <= clk_en;
    end
  end
endmodule

// File: rtl/scs_activation_seq_chk.sv
module scs_activation_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic card_det,
  input logic over_cur,
  input logic osc_fast,
  input logic vcc_en,
  input logic io_en,
  input logic clk_en,
  input logic card_rst,
  input logic status_n
);
  p_rst_needs_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (vcc_en && io_en && clk_en));

  p_io_under_vcc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vcc_en);

  p_clk_under_vcc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> vcc_en);

  p_supply_needs_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_en |-> osc_fast);

  p_overcur_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rst && over_cur) |=> (!card_rst && !status_n));

  p_removal_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rst && !card_det) |=> !card_rst);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_fast |-> !(vcc_en || io_en || clk_en || card_rst));

  p_insert_debounced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_n) |-> card_det);
endmodule

bind scs_activation_seq scs_activation_seq_chk u_chk (.*);

// File: tb/tb_scs_activation_seq.sv
`timescale 1ns/1ps
module tb_scs_activation_seq;
  localparam int TPT  = 16;
  localparam int DEB  = 20;
  localparam int HALF = TPT / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic sess_req_n = 1'b1, host_rst = 1'b0, card_det = 1'b0, supply_ok = 1'b1;
  logic over_cur = 1'b0, over_temp = 1'b0, vcc_off = 1'b1;
  logic osc_fast, vcc_en, io_en, clk_en, card_rst, status_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  scs_activation_seq #(.TICKS_PER_T(TPT), .DEBOUNCE_TICKS(DEB)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sess_req_n(sess_req_n),
    .host_rst(host_rst), .card_det(card_det), .supply_ok(supply_ok),
    .over_cur(over_cur), .over_temp(over_temp), .vcc_off(vcc_off),
    .osc_fast(osc_fast), .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en),
    .card_rst(card_rst), .status_n(status_n)
  );

  // irregular tick pattern: two of every three cycles
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 osc_tick = ((cyc % 3) != 0);
  end

  // ---------------- behavioural reference ----------------
  int m_st = 0;          // 0 idle, 1 ramp, 2 live, 3 down
  int m_ticks = 0;       // ticks seen since entering the phase
  int m_deb = 0;
  bit m_pres = 0, m_armed = 0, m_fault = 0, m_ras = 0, m_go = 0, m_prev = 0;
  bit m_vq = 0, m_iq = 0, m_cq = 0;
  bit e_osc, e_vcc, e_io, e_clk, e_rst, e_stat;

  task automatic expect_now();
    int h;
    h = m_ticks / HALF;
    e_osc  = (m_st != 0);
    e_vcc  = (m_st == 1) || (m_st == 2) || (m_st == 3 && m_vq && h < 3);
    e_io   = (m_st == 1 && h >= 8) || (m_st == 2) || (m_st == 3 && m_iq && h < 2);
    e_clk  = (m_st == 1 && (m_ras ? m_go : (h >= 8))) || (m_st == 2) ||
             (m_st == 3 && m_cq && h < 1);
    e_rst  = (m_st == 2) && host_rst;
    e_stat = m_pres && !m_fault;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ticks = 0; m_deb = 0; m_pres = 0; m_armed = 0; m_fault = 0;
      m_ras = 0; m_go = 0; m_prev = 0; m_vq = 0; m_iq = 0; m_cq = 0;
    end else begin
      int h, nx;
      bit flt, go_now;
      expect_now();
      m_vq = e_vcc; m_iq = e_io; m_cq = e_clk;
      h = m_ticks / HALF;
      flt = (m_st == 1 || m_st == 2) &&
            (over_cur || over_temp || !supply_ok || !card_det);
      go_now = m_armed && !sess_req_n && m_pres && supply_ok;
      nx = m_st;
      case (m_st)
        0: if (go_now) nx = 1;
        1: if (flt || sess_req_n) nx = 3; else if (h >= 14) nx = 2;
        2: if (flt || sess_req_n) nx = 3;
        3: if (h >= 3 && vcc_off) nx = 0;
        default: nx = 0;
      endcase
      if (m_st == 0 && go_now) begin m_ras = host_rst; m_go = 0; end
      else if (m_st == 1 && m_ras && m_prev && !host_rst && h >= 8) m_go = 1;
      if (m_st == 0) begin
        if (go_now) m_armed = 0; else if (sess_req_n) m_armed = 1;
      end
      if (flt) m_fault = 1;
      else if (m_st == 0 && sess_req_n) m_fault = 0;
      if (!card_det) begin m_pres = 0; m_deb = 0; end
      else if (!m_pres && osc_tick) begin
        if (m_deb == DEB - 1) m_pres = 1; else m_deb++;
      end
      m_prev = host_rst;
      if (nx != m_st) m_ticks = 0; else if (osc_tick) m_ticks++;
      m_st = nx;
    end
  end

  task automatic cmp(input bit act, input bit exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      expect_now();
      cmp(osc_fast, e_osc,  "R3 osc_fast");
      cmp(vcc_en,   e_vcc,  "R4 vcc_en");
      cmp(io_en,    e_io,   "R4 io_en");
      cmp(clk_en,   e_clk,  "R6 clk_en");
      cmp(card_rst, e_rst,  "R5 card_rst");
      cmp(status_n, e_stat, "R2 status_n");
    end
  end

  // directed check, sampled at the falling edge
  task automatic chk(input bit act, input bit exp, input string what);
    @(negedge clk);
    cmp(act, exp, what);
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    waitc(5);
    @(negedge clk);
    cmp(vcc_en | io_en | clk_en | card_rst | osc_fast, 1'b0, "R1 outputs after reset");
    cmp(status_n, 1'b0, "R1 status no card");
    rst_n = 1'b1;
    waitc(3);
    card_det = 1'b1;
    waitc(10);
    chk(status_n, 1'b0, "R2 still debouncing");
    waitc(40);
    chk(status_n, 1'b1, "R2 debounced high");
    card_det = 1'b0;
    waitc(1);
    chk(status_n, 1'b0, "R2 removal immediate");
    card_det = 1'b1;
    waitc(45);

    // session with host reset low at start
    host_rst = 1'b0; sess_req_n = 1'b0;
    waitc(250);
    chk(osc_fast, 1'b1, "R3 in session");
    chk(card_rst, 1'b0, "R5 follows low host reset");
    host_rst = 1'b1;
    waitc(1);
    chk(card_rst, 1'b1, "R5 follows high host reset");
    host_rst = 1'b0;
    sess_req_n = 1'b1; vcc_off = 1'b0;
    waitc(100);
    chk(vcc_en, 1'b0, "R7 supply off after 1.5T");
    chk(osc_fast, 1'b1, "R7 waits for vcc_off");
    vcc_off = 1'b1;
    waitc(4);
    chk(osc_fast, 1'b0, "R7 back to idle");

    // session with host reset high at start
    host_rst = 1'b1; sess_req_n = 1'b0;
    waitc(130);
    chk(clk_en, 1'b0, "R6 clock waits for reset fall");
    host_rst = 1'b0;
    waitc(2);
    chk(clk_en, 1'b1, "R6 clock after reset fall");
    waitc(150);
    sess_req_n = 1'b1;
    waitc(60);

    // faults outside a session
    over_temp = 1'b1; over_cur = 1'b1;
    waitc(10);
    chk(osc_fast, 1'b0, "R9 idle ignores faults");
    chk(status_n, 1'b1, "R9 status unaffected");
    over_temp = 1'b0; over_cur = 1'b0;

    // overcurrent in session, lockout, clear
    sess_req_n = 1'b0;
    waitc(250);
    host_rst = 1'b1;
    waitc(2);
    over_cur = 1'b1;
    waitc(1);
    over_cur = 1'b0;
    waitc(2);
    chk(status_n, 1'b0, "R8 overcurrent trips");
    host_rst = 1'b0;
    waitc(100);
    chk(osc_fast, 1'b0, "R10 no restart while held");
    chk(status_n, 1'b0, "R11 fault held until release");
    sess_req_n = 1'b1;
    waitc(2);
    chk(status_n, 1'b1, "R11 fault cleared");
    sess_req_n = 1'b0;
    waitc(20);
    chk(osc_fast, 1'b1, "R10 restart after re-request");

    // card removal during power-up
    waitc(20);
    card_det = 1'b0;
    waitc(2);
    chk(status_n, 1'b0, "R8 removal trips");
    waitc(60);
    chk(vcc_en, 1'b0, "R8 removal powers down");
    sess_req_n = 1'b1; card_det = 1'b1;
    waitc(60);

    // supply dropout in session
    sess_req_n = 1'b0;
    waitc(250);
    supply_ok = 1'b0;
    waitc(2);
    supply_ok = 1'b1;
    chk(status_n, 1'b0, "R8 dropout trips");
    sess_req_n = 1'b1;
    waitc(60);

    // no start without debounced card
    card_det = 1'b0;
    waitc(3);
    sess_req_n = 1'b0;
    waitc(20);
    chk(osc_fast, 1'b0, "R3 no start without card");
    sess_req_n = 1'b1;
    waitc(5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule